// File: doc/BRIEF.md
# Opcode-Driven Watchdog Timer

This block is a watchdog counter that the CPU drives by executing two single-byte instructions. It does not use register writes. The decoder hands it a one-cycle strobe for the arm/refresh opcode (0x5F) and another for the keep-running-in-HALT opcode (0x4F). The first arm strobe turns the watchdog on. Every later arm strobe restarts its count, and no instruction can turn it off again. The power sequencer reports HALT and STOP. A static option input can force the watchdog on permanently, and in that case it counts in every power state.

If the count is not restarted within `TIMEOUT_CYC` clock cycles, the block raises a one-cycle reset request. It also drives a stretched reset that lasts `POR_CYC` cycles (the power-on reset delay) plus `STRETCH_CYC` (18) more cycles. This internal reset clears the enable and the HALT permission, the same as an external reset does. Each arm strobe also produces a flag-update strobe with fixed flag values for the CPU's condition codes.

Top module: `instr_watchdog`

## Requirements
- R1: After `rst_n` is released with `perm_en_i` low, every output is 0 and no reset request is ever raised until an arm strobe arrives.
- R2: The first `op_arm_i` strobe enables the watchdog and starts the count at zero. Without a later strobe, `rst_req_o` pulses high for exactly one cycle, sampled `TIMEOUT_CYC` rising edges after the edge that took the strobe.
- R3: Each `op_arm_i` strobe while enabled restarts the count, so strobes spaced closer than `TIMEOUT_CYC` cycles never produce a reset request.
- R4: `rst_out_o` rises together with `rst_req_o` and stays high for exactly `POR_CYC + STRETCH_CYC` cycles. The watchdog count stays at zero while it is high.
- R5: Once enabled, the watchdog stays enabled whatever opcodes follow. Only `rst_n` or its own reset clears the enable, and after its own reset no request arrives until it is armed again.
- R6: While `halted_i` is high, counting pauses unless `op_halt_run_i` was accepted since the last reset. Accepting that strobe does not restart the count.
- R7: An `op_halt_run_i` strobe while the watchdog is not enabled has no effect: a later HALT still pauses the count.
- R8: A watchdog enabled by software never counts while `stopped_i` is high, even with HALT permission. STOP takes precedence over HALT.
- R9: With `perm_en_i` high, the watchdog enables itself in the first cycle after any reset ends and counts in HALT and in STOP.
- R10: One cycle after an accepted `op_arm_i` strobe, `flag_upd_o` is 1 and `flag_zsv_o` is 3'b100 (bit 2 = zero flag set, bit 1 = sign clear, bit 0 = overflow clear). In all other cycles both outputs are 0.
- R11: The watchdog's own reset clears the HALT permission, so after re-arming, a HALT pauses the count again.
- R12: Opcode strobes that arrive while `rst_out_o` is high are ignored: they produce no flag update and do not enable the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| op_arm_i | input | 1 | Decoded strobe: arm/refresh opcode executed |
| op_halt_run_i | input | 1 | Decoded strobe: keep-running-in-HALT opcode executed |
| halted_i | input | 1 | CPU is in HALT |
| stopped_i | input | 1 | CPU is in STOP |
| perm_en_i | input | 1 | Static option: watchdog permanently on |
| rst_req_o | output | 1 | One-cycle timeout pulse |
| rst_out_o | output | 1 | Stretched reset, POR_CYC + STRETCH_CYC cycles |
| flag_upd_o | output | 1 | Flag-update strobe for the arm opcode |
| flag_zsv_o | output | 3 | Flag values {zero, sign, overflow} during the strobe |

## Verification
A cycle-accurate model in the bench runs alongside the design, and every output is compared with it on every clock. The first pattern arms the watchdog and then leaves it alone. This shows whether the timeout lands on the exact cycle and the stretch has the exact length. Regular refreshes show that a refresh restarts the count rather than merely pausing it. Sequences that combine HALT, STOP and the HALT-permission opcode, each placed before or after arming and before or after a watchdog reset, show the pause rules apart from the stickiness of the enable and the permission. A final run with the permanent option checks that counting continues in STOP and HALT and that the watchdog re-enables itself after its own reset.

// File: rtl/wdt_op_pkg.sv
package wdt_op_pkg;

    typedef struct packed {
        logic z;
        logic s;
        logic v;
    } cc_flags_t;

    localparam cc_flags_t FLAGS_ON_ARM = '{z: 1'b1, s: 1'b0, v: 1'b0};
    localparam cc_flags_t FLAGS_IDLE   = '{z: 1'b0, s: 1'b0, v: 1'b0};

endpackage

// File: rtl/wdt_run_gate.sv
module wdt_run_gate (
    input  logic enabled_i,
    input  logic halted_i,
    input  logic stopped_i,
    input  logic halt_ok_i,
    input  logic perm_i,
    output logic run_o
);

    // STOP outranks HALT; the permanent option overrides both pauses.
    always_comb begin
        if (!enabled_i) begin
            run_o = 1'b0;
        end else if (stopped_i) begin
            run_o = perm_i;
        end else if (halted_i) begin
            run_o = halt_ok_i | perm_i;
        end else begin
            run_o = 1'b1;
        end
    end

endmodule

// File: rtl/wdt_reset_stretch.sv
module wdt_reset_stretch #(
    parameter int POR_CYC     = 32,
    parameter int STRETCH_CYC = 18
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic active_o
);

    localparam int TOTAL = POR_CYC + STRETCH_CYC;
    localparam int W     = $clog2(TOTAL + 1);

    typedef struct packed {
        logic         active;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == W'(TOTAL - 1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end else if (fire_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> !st_q.active); // R4

    AST_STRETCH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> $past(fire_i)); // R4

endmodule

// File: rtl/instr_watchdog.sv
module instr_watchdog #(
    parameter int TIMEOUT_CYC = 64,
    parameter int POR_CYC     = 32,
    parameter int STRETCH_CYC = 18
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_arm_i,
    input  logic       op_halt_run_i,
    input  logic       halted_i,
    input  logic       stopped_i,
    input  logic       perm_en_i,
    output logic       rst_req_o,
    output logic       rst_out_o,
    output logic       flag_upd_o,
    output logic [2:0] flag_zsv_o
);

    import wdt_op_pkg::*;

    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic             en;
        logic             halt_ok;
        logic [CNT_W-1:0] cnt;
        logic             req;
        logic             upd;
    } wd_state_t;

    wd_state_t s_d, s_q;
    logic      run;
    logic      fire;
    logic      wd_rst;

    wdt_run_gate u_gate (
        .enabled_i (s_q.en),
        .halted_i  (halted_i),
        .stopped_i (stopped_i),
        .halt_ok_i (s_q.halt_ok),
        .perm_i    (perm_en_i),
        .run_o     (run)
    );

    wdt_reset_stretch #(
        .POR_CYC     (POR_CYC),
        .STRETCH_CYC (STRETCH_CYC)
    ) u_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .active_o (wd_rst)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        s_d.upd = 1'b0;
        fire    = 1'b0;
        if (wd_rst) begin
            // Own reset in progress: behave like a held system reset.
            s_d.en      = 1'b0;
            s_d.halt_ok = 1'b0;
            s_d.cnt     = '0;
        end else begin
            s_d.upd = op_arm_i;
            if (op_halt_run_i && s_q.en) begin
                s_d.halt_ok = 1'b1;
            end
            if (op_arm_i) begin
                s_d.en  = 1'b1;
                s_d.cnt = '0;
            end else if (run) begin
                if (s_q.cnt == LAST) begin
                    fire    = 1'b1;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            if (perm_en_i) begin
                s_d.en = 1'b1;
            end
        end
        s_d.req = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_req_o  = s_q.req;
    assign rst_out_o  = wd_rst;
    assign flag_upd_o = s_q.upd;
    assign flag_zsv_o = s_q.upd ? FLAGS_ON_ARM : FLAGS_IDLE;

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R2

    AST_REQ_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> rst_out_o); // R4

    AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_o |-> (s_q.cnt == '0)); // R4

    AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !wd_rst && !fire) |=> s_q.en); // R5

    AST_HALT_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_i && !s_q.halt_ok && !perm_en_i && !op_arm_i && !wd_rst)
        |=> $stable(s_q.cnt)); // R6

    AST_HALT_OK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.halt_ok |-> s_q.en); // R7

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_i && !perm_en_i && !op_arm_i && !wd_rst)
        |=> $stable(s_q.cnt)); // R8

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd_o |-> $past(op_arm_i)); // R10

endmodule

// File: tb/instr_watchdog_bench.sv
module instr_watchdog_bench;

    localparam int T_CYC   = 64;
    localparam int POR     = 32;
    localparam int EXTRA   = 18;
    localparam int STRETCH = POR + EXTRA;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_arm = 1'b0;
    logic       op_hr = 1'b0;
    logic       halted = 1'b0;
    logic       stopped = 1'b0;
    logic       perm = 1'b0;
    logic       rst_req, rst_out, flag_upd;
    logic [2:0] flag_zsv;

    instr_watchdog #(
        .TIMEOUT_CYC (T_CYC),
        .POR_CYC     (POR),
        .STRETCH_CYC (EXTRA)
    ) u_instr_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_arm_i      (op_arm),
        .op_halt_run_i (op_hr),
        .halted_i      (halted),
        .stopped_i     (stopped),
        .perm_en_i     (perm),
        .rst_req_o     (rst_req),
        .rst_out_o     (rst_out),
        .flag_upd_o    (flag_upd),
        .flag_zsv_o    (flag_zsv)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int req_seen = 0;
    int out_cycles = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Behavioural reference model
    bit m_en, m_hr, m_act, m_req, m_upd;
    int m_cnt, m_rc;

    always @(posedge clk) begin
        bit fire;
        bit runs;
        bit en_old;
        if (!rst_n) begin
            m_en = 0; m_hr = 0; m_act = 0; m_req = 0; m_upd = 0;
            m_cnt = 0; m_rc = 0;
        end else if (m_act) begin
            m_req = 0; m_upd = 0;
            m_en = 0; m_hr = 0; m_cnt = 0;
            m_rc = m_rc + 1;
            if (m_rc == STRETCH) begin
                m_act = 0;
                m_rc  = 0;
            end
        end else begin
            fire   = 0;
            en_old = m_en;
            if (!en_old)       runs = 0;
            else if (stopped)  runs = perm;
            else if (halted)   runs = m_hr || perm;
            else               runs = 1;
            m_upd = op_arm;
            if (op_hr && en_old) m_hr = 1;
            if (op_arm) begin
                m_en  = 1;
                m_cnt = 0;
            end else if (runs) begin
                if (m_cnt == T_CYC - 1) begin
                    fire  = 1;
                    m_cnt = 0;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            if (perm) m_en = 1;
            m_req = fire;
            if (fire) begin
                m_act = 1;
                m_rc  = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (rst_req !== m_req) begin
                fails++;
                $display("FAIL R2 rst_req_o actual=%0b expected=%0b at cycle %0d", rst_req, m_req, cycles);
            end
            checks++;
            if (rst_out !== m_act) begin
                fails++;
                $display("FAIL R4 rst_out_o actual=%0b expected=%0b at cycle %0d", rst_out, m_act, cycles);
            end
            checks++;
            if (flag_upd !== m_upd || flag_zsv !== (m_upd ? 3'b100 : 3'b000)) begin
                fails++;
                $display("FAIL R10 flags actual=%0b/%b expected=%0b/%b at cycle %0d",
                         flag_upd, flag_zsv, m_upd, (m_upd ? 3'b100 : 3'b000), cycles);
            end
            req_seen   += int'(rst_req);
            out_cycles += int'(rst_out);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<50000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_counts();
        req_seen   = 0;
        out_cycles = 0;
    endtask

    task automatic expect_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_arm();
        op_arm = 1'b1;
        tick();
        op_arm = 1'b0;
    endtask

    task automatic pulse_hr();
        op_hr = 1'b1;
        tick();
        op_hr = 1'b0;
    endtask

    initial begin
        // R1: reset state and idle
        tick(4);
        rst_n = 1'b1;
        tick();
        expect_int("R1 outputs after reset", int'({rst_req, rst_out, flag_upd, flag_zsv}), 0);
        clear_counts();
        tick(200);
        expect_int("R1 no request while unarmed", req_seen, 0);

        // R2 / R10 / R4: arm then leave alone
        pulse_arm();
        expect_int("R10 flag strobe after arm", int'(flag_upd), 1);
        expect_int("R10 flag values after arm", int'(flag_zsv), 4);
        clear_counts();
        tick(T_CYC - 1);
        expect_int("R2 no request before timeout", req_seen, 0);
        clear_counts();
        tick(1);
        expect_int("R2 request on timeout cycle", req_seen, 1);
        tick(STRETCH + 10);
        expect_int("R4 stretched reset length", out_cycles, STRETCH);

        // R5: own reset cleared the enable
        clear_counts();
        tick(200);
        expect_int("R5 no request after own reset", req_seen, 0);

        // R7 then R6: permission before arm is ignored
        pulse_hr();
        pulse_arm();
        halted = 1'b1;
        clear_counts();
        tick(200);
        expect_int("R7 halt permission ignored before arm", req_seen, 0);
        halted = 1'b0;
        tick(T_CYC + 4);
        expect_int("R6 count resumes after HALT", req_seen, 1);
        tick(STRETCH + 4);

        // R3 then R6: refresh, then run in HALT
        pulse_arm();
        pulse_hr();
        clear_counts();
        for (int k = 0; k < 6; k++) begin
            tick(40);
            pulse_arm();
        end
        expect_int("R3 refresh keeps off timeout", req_seen, 0);
        halted = 1'b1;
        tick(T_CYC + 4);
        expect_int("R6 counting in HALT with permission", req_seen, 1);
        halted = 1'b0;
        tick(STRETCH + 4);

        // R11: permission cleared by own reset
        pulse_arm();
        halted = 1'b1;
        clear_counts();
        tick(200);
        expect_int("R11 HALT pauses after own reset", req_seen, 0);
        halted = 1'b0;
        tick(T_CYC + STRETCH + 8);

        // R8 and R5: STOP freezes software watchdog, enable survives
        pulse_arm();
        pulse_hr();
        stopped = 1'b1;
        halted  = 1'b1;
        clear_counts();
        tick(200);
        expect_int("R8 no counting in STOP", req_seen, 0);
        stopped = 1'b0;
        halted  = 1'b0;
        tick(T_CYC + 4);
        expect_int("R5 still enabled after opcodes", req_seen, 1);
        tick(STRETCH + 4);

        // R12: strobes during own reset ignored
        pulse_arm();
        tick(T_CYC + 2);
        op_arm = 1'b1;
        op_hr  = 1'b1;
        tick();
        op_arm = 1'b0;
        op_hr  = 1'b0;
        expect_int("R12 no flag strobe during reset", int'(flag_upd), 0);
        tick(STRETCH);
        clear_counts();
        tick(200);
        expect_int("R12 arm during reset not latched", req_seen, 0);

        // R9: permanent option
        rst_n = 1'b0;
        perm  = 1'b1;
        tick(3);
        rst_n = 1'b1;
        stopped = 1'b1;
        clear_counts();
        tick(T_CYC + 4);
        expect_int("R9 counts in STOP when permanent", req_seen, 1);
        stopped = 1'b0;
        halted  = 1'b1;
        tick(STRETCH + T_CYC + 4);
        expect_int("R9 re-enabled and counts in HALT", req_seen, 2);
        halted = 1'b0;
        tick(10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule